// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block decides where each CPU memory access falls in the legacy upper-memory window, 0xC0000 to 0xFFFFF. That window is split into one 64 KB BIOS segment and twelve 16 KB segments. Each segment has its own 4-bit attribute field. One bit of the field lets reads reach the DRAM shadow, and another bit lets writes reach it. Each access leaves on exactly one of two paths: DRAM or the downstream ROM/bus path.

The attribute fields are packed two to a byte in seven registers. A byte-wide configuration port writes these registers and reads them back, so software can change one segment with a read-modify-write and leave its neighbour untouched. The routing outputs are combinational. They depend on the access address, the access direction and the registered attributes. A configuration write therefore affects the access presented in the cycle after the write edge.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, all seven attribute registers read back 0x00. Every read or write inside the window then goes to the bus path.
- R2: A configuration write to offsets 0x59 to 0x5F stores the whole byte, and it reads back on `cfg_rdata` from the next cycle. Writes to any other offset change nothing, and reading any other offset returns 0x00.
- R3: Segment index n is held in the register at offset 0x59 + n/2. An even n uses bits [3:0] and an odd n uses bits [7:4]. Index 0 maps to no addresses, so its field never affects routing.
- R4: Index 1 covers 0xF0000 to 0xFFFFF. Indices 2 to 9 cover 0xC0000 to 0xDFFFF in ascending 16 KB steps. Indices 10 to 13 cover 0xE0000 to 0xEFFFF in ascending 16 KB steps.
- R5: A read in a segment whose field bit 0 (read enable) is 1 asserts `dram_sel`. If that bit is 0, the read asserts `bus_sel`.
- R6: A write in a segment whose field bit 1 (write enable) is 1 asserts `dram_sel`. If that bit is 0, the write goes to the bus path (`bus_sel`) and DRAM is not selected.
- R7: Field bits 3:2 read back as written and have no effect on routing.
- R8: Any access outside 0xC0000 to 0xFFFFF, including addresses at or above 0x100000, asserts `dram_sel` whatever the registers hold.
- R9: While `acc_valid` is 1, exactly one of `dram_sel` and `bus_sel` is 1. While `acc_valid` is 0, both are 0.
- R10: An access presented in the same cycle as a configuration write is routed by the old value. From the next cycle it is routed by the new value.
- R11: A read-modify-write that changes one field of a register leaves the other field of that register unchanged, both in readback and in routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for write and readback |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the register at `cfg_addr` |
| acc_valid | input | 1 | CPU access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | CPU access byte address |
| dram_sel | output | 1 | Access goes to DRAM shadow |
| bus_sel | output | 1 | Access goes to ROM/bus path |

## Verification
Suppose a register holds a wrong bit, or the decoder picks the wrong register or nibble. The fault appears on `dram_sel`/`bus_sel` in the same cycle that an access hits the affected segment. It also appears on `cfg_rdata` as soon as that offset is addressed. The stimulus therefore programs a single field and then probes the first and last 16 KB boundaries next to it, so that an off-by-one segment or a swapped nibble flips the route right away. It also probes addresses just outside the window and above 1 MB.

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder #(
  parameter int ADDR_W = 32,
  parameter int NREG = 7,
  parameter logic [7:0] CFG_BASE = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              dram_sel,
  output logic              bus_sel
);
  localparam int SEL_W = $clog2(NREG);

  logic [7:0] attr [NREG];
  logic [7:0] cfg_off;
  logic       cfg_hit;

  assign cfg_off = cfg_addr - CFG_BASE;
  assign cfg_hit = (cfg_addr >= CFG_BASE) && (cfg_off < 8'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr[g] <= 8'h00;
      else if (cfg_wr_en && cfg_hit && cfg_off == 8'(g))
        attr[g] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_hit ? attr[cfg_off[SEL_W-1:0]] : 8'h00;

  logic hi_zero;
  if (ADDR_W > 20) begin : g_hi
    assign hi_zero = ~|acc_addr[ADDR_W-1:20];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  logic       in_win;
  logic [3:0] seg_idx;
  logic [7:0] sel_reg;
  logic [3:0] nib;
  logic       allow;

  assign in_win  = hi_zero && (acc_addr[19:18] == 2'b11);
  assign seg_idx = (acc_addr[17:16] == 2'b11) ? 4'd1 : acc_addr[17:14] + 4'd2;
  assign sel_reg = attr[seg_idx[3:1]];
  assign nib     = seg_idx[0] ? sel_reg[7:4] : sel_reg[3:0];
  assign allow   = acc_write ? nib[1] : nib[0];

  assign dram_sel = acc_valid && (!in_win || allow);
  assign bus_sel  = acc_valid && in_win && !allow;

  logic unused_ok;
  assign unused_ok = ^{acc_addr[13:0], cfg_off[7:SEL_W], nib[3:2]};
endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int NREG = 7,
  parameter logic [7:0] CFG_BASE = 8'h59
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [7:0]        cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              dram_sel,
  input logic              bus_sel
);
  logic in_range;
  logic outside;
  assign in_range = (int'(cfg_addr) >= int'(CFG_BASE)) && (int'(cfg_addr) < int'(CFG_BASE) + NREG);
  assign outside  = (acc_addr < ADDR_W'('hC0000)) || (acc_addr > ADDR_W'('hFFFFF));

  logic unused_ok;
  assign unused_ok = acc_write;

  // R9
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({dram_sel, bus_sel}) == 1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !dram_sel && !bus_sel);

  // R8
  outside_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && outside) |-> dram_sel);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && in_range) ##1 (cfg_addr == $past(cfg_addr)) |-> cfg_rdata == $past(cfg_wdata));

  // R2
  foreign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> cfg_rdata == 8'h00);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_rdata == 8'h00);
endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(.ADDR_W(ADDR_W), .NREG(NREG), .CFG_BASE(CFG_BASE)) u_chk (.*);

// File: tb/test_shadow_attr_decoder.sv
module test_shadow_attr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        dram_sel;
  logic        bus_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shadow_attr_decoder i_shadow_attr_decoder (.*);

  // {offset, value, address, write, exp_dram, exp_bus}
  localparam int NV = 14;
  localparam logic [50:0] VEC [NV] = '{
    {8'h59, 8'h10, 32'h000F8000, 1'b0, 1'b1, 1'b0},  // R5 R4 index1 RE
    {8'h59, 8'h10, 32'h000F8000, 1'b1, 1'b0, 1'b1},  // R6 WE clear
    {8'h59, 8'h01, 32'h000FFFFF, 1'b0, 1'b0, 1'b1},  // R3 index0 no effect
    {8'h5A, 8'h02, 32'h000C0000, 1'b1, 1'b1, 1'b0},  // R6 index2 WE
    {8'h5A, 8'h02, 32'h000C3FFF, 1'b0, 1'b0, 1'b1},  // R5 RE clear
    {8'h5A, 8'h10, 32'h000C4000, 1'b0, 1'b1, 1'b0},  // R3 R4 index3 high nibble
    {8'h5A, 8'h10, 32'h000C3FFF, 1'b0, 1'b0, 1'b1},  // R4 boundary
    {8'h5D, 8'h30, 32'h000DFFFF, 1'b1, 1'b1, 1'b0},  // R4 index9
    {8'h5D, 8'h03, 32'h000DC000, 1'b0, 1'b0, 1'b1},  // R3 index8 set, index9 clear
    {8'h5F, 8'h20, 32'h000EC000, 1'b1, 1'b1, 1'b0},  // R4 index13 WE
    {8'h5F, 8'h0C, 32'h000E8000, 1'b0, 1'b0, 1'b1},  // R7 reserved bits
    {8'h5E, 8'h01, 32'h000E0000, 1'b0, 1'b1, 1'b0},  // R4 index10 RE
    {8'h5F, 8'h00, 32'h000BFFFF, 1'b0, 1'b1, 1'b0},  // R8 below window
    {8'h5F, 8'h00, 32'h00100000, 1'b1, 1'b1, 1'b0}   // R8 above 1 MB
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = off; cfg_wdata = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic route(input logic [31:0] a, input logic w, input logic ed, input logic eb, input string req);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    #1;
    check({dram_sel, bus_sel} == {ed, eb}, req, {30'b0, dram_sel, bus_sel}, {30'b0, ed, eb});
  endtask

  task automatic readback(input logic [7:0] off, input logic [7:0] exp, input string req);
    cfg_addr = off;
    #1;
    check(cfg_rdata == exp, req, {24'b0, cfg_rdata}, {24'b0, exp});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] tmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 7; r++) readback(8'(8'h59 + r), 8'h00, "R1 reset value");
    route(32'h000F0000, 1'b0, 1'b0, 1'b1, "R1 reset read to bus");
    route(32'h000C0000, 1'b1, 1'b0, 1'b1, "R1 reset write to bus");

    acc_valid = 1'b0;
    #1;
    check(!dram_sel && !bus_sel, "R9 idle", {30'b0, dram_sel, bus_sel}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][50:43], VEC[i][42:35]);
      route(VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R5 R6 vector %0d", i));
    end
    acc_valid = 1'b0;

    @(negedge clk);
    cfg_write(8'h5B, 8'hA5);
    readback(8'h5B, 8'hA5, "R2 readback");
    tmp = cfg_rdata;
    cfg_write(8'h5B, (tmp & 8'h0F) | 8'h10);
    readback(8'h5B, 8'h15, "R11 RMW keeps low nibble");
    route(32'h000C8000, 1'b0, 1'b1, 1'b0, "R11 low field still RE");
    route(32'h000CC000, 1'b0, 1'b1, 1'b0, "R11 high field RE");
    route(32'h000CC000, 1'b1, 1'b0, 1'b1, "R11 high field WE clear");
    acc_valid = 1'b0;

    cfg_write(8'h5F, 8'hCC);
    readback(8'h5F, 8'hCC, "R7 reserved bits read back");
    route(32'h000EC000, 1'b0, 1'b0, 1'b1, "R7 reserved no read effect");
    route(32'h000E8000, 1'b1, 1'b0, 1'b1, "R7 reserved no write effect");
    acc_valid = 1'b0;

    cfg_write(8'h59, 8'h33);
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    readback(8'h58, 8'h00, "R2 foreign offset low");
    readback(8'h60, 8'h00, "R2 foreign offset high");
    readback(8'h59, 8'h33, "R2 neighbour untouched");
    readback(8'h5F, 8'hCC, "R2 last register untouched");

    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 8'h5C; cfg_wdata = 8'h11;
    route(32'h000D0000, 1'b0, 1'b0, 1'b1, "R10 old value same cycle");
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
    check(dram_sel && !bus_sel, "R10 new value next cycle", {30'b0, dram_sel, bus_sel}, 32'h2);
    acc_valid = 1'b0;

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule